// File: doc/BRIEF.md
# Four-Phase LED Lane Serializer

This block feeds an external cascade of serial-in, parallel-out shift registers so that a single three-wire link can drive many self-clocked LED strings in parallel. Each LED bit period is cut into four sub-slots of equal length. The lanes are high in the first sub-slot, carry their data bit in the second, and are low in the last two. Every sub-slot is sent to the external chain as one serial word, most significant bit first, and a latch strobe then transfers the whole word onto the parallel pins. All lanes therefore switch on the same edge.

An upstream sequencer supplies two words per LED bit: a lead word, which is normally all ones, and a data word with one bit per lane. The block captures both through a valid/ready handshake once per LED bit period, at the last cycle before the lead sub-slot starts. It then pulses a request so that the next pair can be prepared a full period ahead. If nothing is offered at the capture point, the block sends zeros in both the lead and data sub-slots and raises a sticky underrun flag. The timing engine never pauses.

The serial bit clock runs at half the core clock. With 32 lanes and a 204.8 MHz core clock, the bit clock is 102.4 MHz, each sub-slot lasts 312.5 ns and the LED bit rate is 800 kHz.

Top module: `ledbit_serializer`

## Requirements
- R1: Each of the four sub-slots lasts exactly 2*LANES core cycles. `latch_clk` is high for one cycle every 2*LANES cycles, with no gap between words.
- R2: Words are shifted out starting at bit LANES-1. After a latch, external lane i carries bit i of the word that was just shifted.
- R3: In the first sub-slot of an LED bit, the lanes show the lead word that was accepted for that bit.
- R4: In the second sub-slot, the lanes show the data word that was accepted for that bit.
- R5: In the third and fourth sub-slots, every lane is zero.
- R6: `ser_clk` toggles on every core cycle and is low in the first cycle after reset. `ser_data` changes only while `ser_clk` is low, so each rising edge shifts in exactly one stable bit.
- R7: `latch_clk` goes high in the cycle right after the final rising bit-clock edge of a word, while `ser_clk` is low.
- R8: `in_ready` is high for exactly one cycle per LED bit period, at core cycle 2*LANES-1 modulo 8*LANES after reset release. A word pair transfers when `in_valid` and `in_ready` are both high.
- R9: `data_req` pulses for one cycle in the cycle after every capture point.
- R10: If `in_valid` is low at a capture point, the lead and data sub-slots of that LED bit are all zero and `underrun` is set. `underrun` stays set until reset.
- R11: During reset, `ser_clk`, `ser_data`, `latch_clk`, `data_req`, `in_ready` and `underrun` are low. The first word shifted after reset is all zeros and counts as a trailing sub-slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the serial bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| in_lead_word | input | LANES | Word shown on the lanes in the first sub-slot |
| in_data_word | input | LANES | Per-lane data bit shown in the second sub-slot |
| in_valid | input | 1 | Upstream offers a word pair |
| in_ready | output | 1 | Capture point; pair accepted when valid is also high |
| data_req | output | 1 | One-cycle pulse after each capture point |
| underrun | output | 1 | Sticky flag: a capture point found no valid pair |
| ser_data | output | 1 | Serial data to the external register chain |
| ser_clk | output | 1 | Serial bit clock to the external register chain |
| latch_clk | output | 1 | Storage strobe that moves a full word to the lane pins |

## Verification
The bench builds the block with LANES=4, so one sub-slot takes eight core cycles and one LED bit takes thirty-two. At that width a single run can offer every one of the 256 lead/data combinations in consecutive periods. A model of the external register chain compares every latched word with the expected value, which covers lane mapping and sub-slot order for all bit patterns. The same run also starves the block for several periods and then resumes, which exercises the zero-fill and sticky-flag path and the return to normal output after it.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
    // Sub-slot order within one LED bit; the sequence is behaviour.
    typedef enum logic [1:0] {
        PH_LEAD   = 2'd0,
        PH_DATA   = 2'd1,
        PH_TAIL_A = 2'd2,
        PH_TAIL_B = 2'd3
    } phase_e;

    localparam int unsigned NUM_PHASES = 4;
endpackage

// File: rtl/lsr_timebase.sv
module lsr_timebase
    import lsr_pkg::*;
#(
    parameter int unsigned LANES = 32
) (
    input  logic   clk,
    input  logic   rst_n,
    output logic   half_o,
    output logic   word_end_o,
    output logic   period_end_o,
    output phase_e next_phase_o
);
    localparam int unsigned BIT_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(LANES - 1);

    typedef struct packed {
        logic             half;
        logic [BIT_W-1:0] bitidx;
        phase_e           phase;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic      word_end;

    always_comb begin
        st_d     = st_q;
        word_end = st_q.half && (st_q.bitidx == LAST_BIT);
        st_d.half = ~st_q.half;
        if (st_q.half) begin
            if (word_end) begin
                st_d.bitidx = '0;
                st_d.phase  = phase_e'(st_q.phase + 2'd1);
            end else begin
                st_d.bitidx = st_q.bitidx + BIT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.half   <= 1'b0;
            st_q.bitidx <= '0;
            st_q.phase  <= PH_TAIL_B;
        end else begin
            st_q <= st_d;
        end
    end

    assign half_o       = st_q.half;
    assign word_end_o   = word_end;
    assign period_end_o = word_end && (st_q.phase == PH_TAIL_B);
    assign next_phase_o = phase_e'(st_q.phase + 2'd1);
endmodule

// File: rtl/lsr_word_fetch.sv
module lsr_word_fetch #(
    parameter int unsigned LANES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             period_end_i,
    input  logic             in_valid_i,
    input  logic [LANES-1:0] in_lead_i,
    input  logic [LANES-1:0] in_data_i,
    output logic [LANES-1:0] lead_now_o,
    output logic [LANES-1:0] data_hold_o,
    output logic             in_ready_o,
    output logic             data_req_o,
    output logic             underrun_o
);
    typedef struct packed {
        logic [LANES-1:0] data_hold;
        logic             underrun;
        logic             req;
    } wf_state_t;

    wf_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = period_end_i;
        if (period_end_i) begin
            if (in_valid_i) begin
                st_d.data_hold = in_data_i;
            end else begin
                st_d.data_hold = '0;
                st_d.underrun  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lead_now_o  = in_valid_i ? in_lead_i : '0;
    assign data_hold_o = st_q.data_hold;
    assign in_ready_o  = period_end_i;
    assign data_req_o  = st_q.req;
    assign underrun_o  = st_q.underrun;
endmodule

// File: rtl/lsr_shift_out.sv
module lsr_shift_out
    import lsr_pkg::*;
#(
    parameter int unsigned LANES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             half_i,
    input  logic             word_end_i,
    input  phase_e           next_phase_i,
    input  logic [LANES-1:0] lead_now_i,
    input  logic [LANES-1:0] data_hold_i,
    output logic             ser_data_o,
    output logic             latch_o
);
    typedef struct packed {
        logic [LANES-1:0] shreg;
        logic             latch;
    } so_state_t;

    so_state_t        st_d, st_q;
    logic [LANES-1:0] next_word;

    always_comb begin
        unique case (next_phase_i)
            PH_LEAD: next_word = lead_now_i;
            PH_DATA: next_word = data_hold_i;
            default: next_word = '0;
        endcase
    end

    always_comb begin
        st_d       = st_q;
        st_d.latch = word_end_i;
        if (word_end_i) begin
            st_d.shreg = next_word;
        end else if (half_i) begin
            st_d.shreg = {st_q.shreg[LANES-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_data_o = st_q.shreg[LANES-1];
    assign latch_o    = st_q.latch;
endmodule

// File: rtl/ledbit_serializer.sv
module ledbit_serializer
    import lsr_pkg::*;
#(
    parameter int unsigned LANES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] in_lead_word,
    input  logic [LANES-1:0] in_data_word,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             data_req,
    output logic             underrun,
    output logic             ser_data,
    output logic             ser_clk,
    output logic             latch_clk
);
    logic             half;
    logic             word_end;
    logic             period_end;
    phase_e           next_phase;
    logic [LANES-1:0] lead_now;
    logic [LANES-1:0] data_hold;

    lsr_timebase #(.LANES(LANES)) u_timebase (
        .clk          (clk),
        .rst_n        (rst_n),
        .half_o       (half),
        .word_end_o   (word_end),
        .period_end_o (period_end),
        .next_phase_o (next_phase)
    );

    lsr_word_fetch #(.LANES(LANES)) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_end_i (period_end),
        .in_valid_i   (in_valid),
        .in_lead_i    (in_lead_word),
        .in_data_i    (in_data_word),
        .lead_now_o   (lead_now),
        .data_hold_o  (data_hold),
        .in_ready_o   (in_ready),
        .data_req_o   (data_req),
        .underrun_o   (underrun)
    );

    lsr_shift_out #(.LANES(LANES)) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .half_i       (half),
        .word_end_i   (word_end),
        .next_phase_i (next_phase),
        .lead_now_i   (lead_now),
        .data_hold_i  (data_hold),
        .ser_data_o   (ser_data),
        .latch_o      (latch_clk)
    );

    assign ser_clk = half;
endmodule

// File: rtl/ledbit_serializer_chk.sv
module ledbit_serializer_chk #(
    parameter int unsigned LANES = 32
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic data_req,
    input logic underrun,
    input logic ser_data,
    input logic ser_clk,
    input logic latch_clk
);
    localparam int unsigned GAP = 2 * LANES - 1;

    int unsigned gap_q;
    logic        seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= 0;
            seen_q <= 1'b0;
        end else if (latch_clk) begin
            gap_q  <= 0;
            seen_q <= 1'b1;
        end else begin
            gap_q <= gap_q + 1;
        end
    end

    // R1
    latch_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_clk && seen_q) |-> (gap_q == GAP));
    // R1
    latch_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_clk |=> !latch_clk);
    // R6
    data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> $stable(ser_data));
    // R6
    clk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_clk |=> ser_clk);
    // R7
    latch_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_clk |-> !ser_clk);
    // R8
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> !in_ready);
    // R9
    req_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> data_req);
    // R10
    underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);
    // R10
    underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> underrun);
endmodule

bind ledbit_serializer ledbit_serializer_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .data_req  (data_req),
    .underrun  (underrun),
    .ser_data  (ser_data),
    .ser_clk   (ser_clk),
    .latch_clk (latch_clk)
);

// File: tb/ledbit_serializer_bench.sv
module ledbit_serializer_bench;
    localparam int LANES      = 4;
    localparam int CLK_PERIOD = 10;
    localparam int PH         = 2 * LANES;
    localparam int PER        = 8 * LANES;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LANES-1:0] in_lead_word = '0;
    logic [LANES-1:0] in_data_word = '0;
    logic             in_valid = 1'b0;
    logic             in_ready, data_req, underrun, ser_data, ser_clk, latch_clk;

    int errors = 0;
    int checks = 0;
    int cyc;
    logic mon_en = 1'b0;
    logic exp_und = 1'b0;
    logic prev_data = 1'b0;
    logic [LANES-1:0] chain = '0;
    logic [LANES-1:0] exp_w[$];
    string            exp_tag[$];

    ledbit_serializer #(.LANES(LANES)) u_ledbit_serializer (
        .clk(clk), .rst_n(rst_n), .in_lead_word(in_lead_word),
        .in_data_word(in_data_word), .in_valid(in_valid), .in_ready(in_ready),
        .data_req(data_req), .underrun(underrun), .ser_data(ser_data),
        .ser_clk(ser_clk), .latch_clk(latch_clk)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // External register chain model: shift on bit clock, store on latch.
    always @(posedge ser_clk) chain <= {chain[LANES-2:0], ser_data};

    always @(posedge latch_clk) begin
        if (exp_w.size() == 0) begin
            check(1'b0, "R2 latch with no expected word", int'(chain), 0);
        end else begin
            logic [LANES-1:0] w;
            string t;
            w = exp_w.pop_front();
            t = exp_tag.pop_front();
            // R2 lane i = word bit i; tag names R3/R4/R5/R10/R11 per sub-slot
            check(chain == w, t, int'(chain), int'(w));
        end
    end

    always @(negedge clk) begin
        if (mon_en) begin
            // R8 capture point timing
            check(in_ready == ((cyc % PER) == PH - 1), "R8 in_ready", in_ready, (cyc % PER) == PH - 1);
            // R1 R7 latch timing
            check(latch_clk == (cyc > 0 && (cyc % PH) == 0), "R1 R7 latch_clk", latch_clk,
                  cyc > 0 && (cyc % PH) == 0);
            // R9 request pulse
            check(data_req == (cyc > 0 && (cyc % PER) == PH), "R9 data_req", data_req,
                  cyc > 0 && (cyc % PER) == PH);
            // R6 bit clock and data stability
            check(ser_clk == cyc[0], "R6 ser_clk", ser_clk, cyc[0]);
            if (ser_clk) check(ser_data == prev_data, "R6 ser_data stable", ser_data, prev_data);
            prev_data = ser_data;
            // R10 sticky flag
            check(underrun == exp_und, "R10 underrun", underrun, exp_und);
            if (in_ready) begin
                if (in_valid) begin
                    exp_w.push_back(in_lead_word); exp_tag.push_back("R3 lead sub-slot");
                    exp_w.push_back(in_data_word); exp_tag.push_back("R4 data sub-slot");
                end else begin
                    exp_und = 1'b1;
                    exp_w.push_back('0); exp_tag.push_back("R10 zero lead");
                    exp_w.push_back('0); exp_tag.push_back("R10 zero data");
                end
                exp_w.push_back('0); exp_tag.push_back("R5 tail A");
                exp_w.push_back('0); exp_tag.push_back("R5 tail B");
            end
        end
    end

    task automatic wait_capture();
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
    endtask

    task automatic send(input logic [LANES-1:0] lead, input logic [LANES-1:0] data);
        @(negedge clk);
        in_valid     = 1'b1;
        in_lead_word = lead;
        in_data_word = data;
        wait_capture();
    endtask

    initial begin
        exp_w.push_back('0);
        exp_tag.push_back("R11 first word zero");
        repeat (3) @(negedge clk);
        // R11 reset state
        check({ser_clk, ser_data, latch_clk, data_req, in_ready, underrun} == 6'b0,
              "R11 reset outputs", {ser_clk, ser_data, latch_clk, data_req, in_ready, underrun}, 0);
        rst_n  = 1'b1;
        mon_en = 1'b1;
        for (int h = 0; h < (1 << LANES); h++) begin
            for (int d = 0; d < (1 << LANES); d++) begin
                send(LANES'(h), LANES'(d));
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) wait_capture();
        send('1, LANES'(4'hA));
        send('1, LANES'(4'h5));
        send(LANES'(4'h3), '1);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2 * PER + 4) @(negedge clk);
        check(underrun == 1'b1, "R10 final underrun", underrun, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule